// File: doc/BRIEF.md
# Decode-Stage Conditional Branch Resolver

This block settles conditional branches while the branch is still in decode. It checks whether one register operand is zero and adds a sign-extended offset to the address of the delay-slot instruction. It then tells fetch where to go next. The instruction that follows a branch always issues, because the redirect only takes effect after that one slot. Resolving in decode leaves a single cycle of penalty, and the slot hides that cycle.

A branch can be marked as cancelling and carries a predicted direction. If a cancelling branch goes the predicted way, its slot runs as normal. If it goes the other way, the block raises a squash flag while the slot instruction sits in decode. The surrounding pipeline uses that flag to clear all the slot's register and memory write-enables, and fetch keeps running. The older instruction, one stage ahead, may be about to write the register being tested. In that case the block stalls decode for a cycle instead of testing a stale value.

Top module: `branch_resolver`

## Requirements
- R1: The branch kind `idBrType` is coded 2'b01 for "taken when the operand is zero" and 2'b10 for "taken when the operand is non-zero". With `idValid` high and no stall or squash, `taken` follows that rule in the same cycle.
- R2: When `taken` is high, `nextPc` equals `idPc + 4 + signext(idOffset)`. The 16-bit offset is sign-extended to 32 bits.
- R3: When `taken` is low, `nextPc` equals `fetchPcPlus4`, the address after the delay slot.
- R4: When `idValid` is low, or `idBrType` is 2'b00 or the reserved 2'b11, `taken` and `stall` stay low and no squash follows.
- R5: A branch with `idCancel` low never raises `squashSlot` in the following cycle, whichever way it goes.
- R6: A branch with `idCancel` high raises `squashSlot` in the next cycle exactly when its outcome differs from `idPredict` (1 = predicted taken). The flag lasts one cycle.
- R7: A valid branch whose `idRegIdx` equals `exWrIdx` while `exWrEn` is high drives `stall` high and `taken` low. It leaves `squashSlot` low for the next cycle. Once the hazard clears, the branch resolves normally.
- R8: An instruction in decode while `squashSlot` is high is never resolved as a branch. It gives no redirect, no stall and no squash after it.
- R9: After reset, `squashSlot` is low.
- R10: A matching `exWrIdx` with a non-branch in decode does not raise `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idValid | input | 1 | Decode holds a real instruction |
| idBrType | input | 2 | Branch kind: 00 none, 01 zero, 10 non-zero, 11 reserved |
| idCancel | input | 1 | Branch is cancelling |
| idPredict | input | 1 | Predicted direction, 1 = taken |
| idRegVal | input | 32 | Tested register value |
| idRegIdx | input | 5 | Tested register index |
| idPc | input | 32 | Address of the branch |
| idOffset | input | 16 | Signed byte offset from the slot address |
| fetchPcPlus4 | input | 32 | Address after the delay slot |
| exWrEn | input | 1 | Instruction ahead writes a register |
| exWrIdx | input | 5 | Register written by the instruction ahead |
| nextPc | output | 32 | Next fetch address |
| taken | output | 1 | Redirect fetch to the target |
| stall | output | 1 | Hold decode and fetch for one cycle |
| squashSlot | output | 1 | Current decode instruction is a nullified slot |

## Verification
Both branch kinds are tried with a zero operand and with non-zero operands, including a value that has only the top bit set. This tells a full-width zero test apart from one that looks at only some bits. Positive and negative offsets check the sign extension and confirm the base is the slot address, not the branch address. Cancelling branches are run in all four combinations of predicted and actual direction, next to non-cancelling mispredictions, to separate R5 from R6. Further cases cover the hazard stall, a branch placed in a squashed slot, and a register match on a non-branch. Together they show that stall and squash are gated only by real branches.

// File: rtl/br_pkg.sv
`timescale 1ns/1ps
package br_pkg;
  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_EQZ  = 2'b01,
    BR_NEZ  = 2'b10,
    BR_RSVD = 2'b11
  } brKind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic redirect;
    logic hold;
  } brCtrl_t;

  // datapath -> control status
  typedef struct packed {
    logic regZero;
    logic producerHit;
  } brStat_t;
endpackage

// File: rtl/br_datapath.sv
`timescale 1ns/1ps
module br_datapath
  import br_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OW = 16,
  parameter int RW = 5,
  parameter int INSN_BYTES = 4
) (
  input  logic [DW-1:0] idRegVal,
  input  logic [RW-1:0] idRegIdx,
  input  logic [AW-1:0] idPc,
  input  logic [OW-1:0] idOffset,
  input  logic [AW-1:0] fetchPcPlus4,
  input  logic          exWrEn,
  input  logic [RW-1:0] exWrIdx,
  input  brCtrl_t       ctrl,
  output brStat_t       stat,
  output logic [AW-1:0] nextPc
);
  localparam logic [AW-1:0] SLOT_STEP = AW'(INSN_BYTES);

  logic [AW-1:0] offExt;
  logic [AW-1:0] slotPc;
  logic [AW-1:0] targetPc;

  generate
    if (OW < AW) begin : g_sext
      assign offExt = {{(AW-OW){idOffset[OW-1]}}, idOffset};
    end else begin : g_trunc
      assign offExt = idOffset[AW-1:0];
    end
  endgenerate

  assign slotPc   = idPc + SLOT_STEP;
  assign targetPc = slotPc + offExt;

  always_comb begin
    stat.regZero     = (idRegVal == '0);
    stat.producerHit = exWrEn && (exWrIdx == idRegIdx);
  end

  always_comb begin
    if (ctrl.redirect && !ctrl.hold) nextPc = targetPc;
    else                             nextPc = fetchPcPlus4;
  end
endmodule

// File: rtl/br_control.sv
`timescale 1ns/1ps
module br_control
  import br_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idValid,
  input  logic [1:0] idBrType,
  input  logic       idCancel,
  input  logic       idPredict,
  input  brStat_t    stat,
  output brCtrl_t    ctrl,
  output logic       taken,
  output logic       stall,
  output logic       squashSlot
);
  brKind_e kind;
  logic    isBranch;
  logic    condMet;
  logic    squashNext;

  assign kind = brKind_e'(idBrType);

  always_comb begin
    isBranch = idValid && !squashSlot && ((kind == BR_EQZ) || (kind == BR_NEZ));
    condMet  = (kind == BR_EQZ) ? stat.regZero : !stat.regZero;
    stall    = isBranch && stat.producerHit;
    taken    = isBranch && !stall && condMet;
    squashNext = isBranch && !stall && idCancel && (condMet != idPredict);
    ctrl.redirect = taken;
    ctrl.hold     = stall;
  end

  // squash flag follows the branch into the slot's decode cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      squashSlot <= 1'b0;
    else if (!stall) squashSlot <= squashNext;
  end
endmodule

// File: rtl/branch_resolver.sv
`timescale 1ns/1ps
module branch_resolver
  import br_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OW = 16,
  parameter int RW = 5,
  parameter int INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idValid,
  input  logic [1:0]    idBrType,
  input  logic          idCancel,
  input  logic          idPredict,
  input  logic [DW-1:0] idRegVal,
  input  logic [RW-1:0] idRegIdx,
  input  logic [AW-1:0] idPc,
  input  logic [OW-1:0] idOffset,
  input  logic [AW-1:0] fetchPcPlus4,
  input  logic          exWrEn,
  input  logic [RW-1:0] exWrIdx,
  output logic [AW-1:0] nextPc,
  output logic          taken,
  output logic          stall,
  output logic          squashSlot
);
  brCtrl_t ctrl;
  brStat_t stat;

  br_control u_ctl (
    .clk(clk), .rst_n(rst_n), .idValid(idValid), .idBrType(idBrType),
    .idCancel(idCancel), .idPredict(idPredict), .stat(stat), .ctrl(ctrl),
    .taken(taken), .stall(stall), .squashSlot(squashSlot)
  );

  br_datapath #(.AW(AW), .DW(DW), .OW(OW), .RW(RW), .INSN_BYTES(INSN_BYTES)) u_dp (
    .idRegVal(idRegVal), .idRegIdx(idRegIdx), .idPc(idPc), .idOffset(idOffset),
    .fetchPcPlus4(fetchPcPlus4), .exWrEn(exWrEn), .exWrIdx(exWrIdx),
    .ctrl(ctrl), .stat(stat), .nextPc(nextPc)
  );
endmodule

// File: rtl/branch_resolver_checker.sv
`timescale 1ns/1ps
module branch_resolver_checker #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OW = 16,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idValid,
  input logic [1:0]    idBrType,
  input logic          idCancel,
  input logic [DW-1:0] idRegVal,
  input logic [AW-1:0] fetchPcPlus4,
  input logic [AW-1:0] nextPc,
  input logic          taken,
  input logic          stall,
  input logic          squashSlot
);
  assert_eqz_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && idBrType == 2'b01) |-> (idRegVal == '0));
  assert_nez_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && idBrType == 2'b10) |-> (idRegVal != '0));
  assert_fallthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> (nextPc == fetchPcPlus4));
  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !idValid |-> (!taken && !stall));
  assert_plain_nosquash_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idValid && !idCancel) |=> !squashSlot);
  assert_squash_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    squashSlot |-> $past(idValid && idCancel && !stall));
  assert_squash_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    squashSlot |=> !squashSlot);
  assert_stall_notaken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !taken);
  assert_stall_nosquash_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !squashSlot);
  assert_slot_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    squashSlot |-> (!taken && !stall));
endmodule

bind branch_resolver branch_resolver_checker #(.AW(AW), .DW(DW), .OW(OW), .RW(RW)) u_chk (.*);

// File: tb/branch_resolver_bench.sv
`timescale 1ns/1ps
module branch_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        idValid, idCancel, idPredict, exWrEn;
  logic [1:0]  idBrType;
  logic [31:0] idRegVal, idPc, fetchPcPlus4, nextPc;
  logic [4:0]  idRegIdx, exWrIdx;
  logic [15:0] idOffset;
  logic        taken, stall, squashSlot;
  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  branch_resolver u_branch_resolver (.*);

  function automatic logic [31:0] tgt(input logic [31:0] pc, input logic [15:0] off);
    return pc + 32'd4 + {{16{off[15]}}, off};
  endfunction

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] t, input logic c, input logic p,
                       input logic [31:0] r, input logic [4:0] ri, input logic [31:0] pc,
                       input logic [15:0] off, input logic we, input logic [4:0] wi);
    @(negedge clk);
    idValid = v; idBrType = t; idCancel = c; idPredict = p; idRegVal = r; idRegIdx = ri;
    idPc = pc; idOffset = off; fetchPcPlus4 = pc + 32'd8; exWrEn = we; exWrIdx = wi;
    #2;
  endtask

  task automatic slotNop(input string req, input logic expSquash);
    drive(1'b1, 2'b00, 1'b0, 1'b0, 32'd0, 5'd0, 32'h0000_4000, 16'd0, 1'b0, 5'd0);
    cmp(req, "squashSlot", {31'd0, squashSlot}, {31'd0, expSquash});
  endtask

  task automatic t_reset;
    cmp("R9", "squashSlot after reset", {31'd0, squashSlot}, 32'd0);
    drive(1'b0, 2'b01, 1'b0, 1'b0, 32'd0, 5'd3, 32'h100, 16'h10, 1'b0, 5'd0);
    cmp("R4", "taken invalid", {31'd0, taken}, 32'd0);
    cmp("R4", "nextPc invalid", nextPc, 32'h108);
  endtask

  task automatic t_eqz;
    drive(1'b1, 2'b01, 1'b0, 1'b0, 32'd0, 5'd3, 32'h1000, 16'h0040, 1'b0, 5'd0);
    cmp("R1", "eqz zero taken", {31'd0, taken}, 32'd1);
    cmp("R2", "eqz target", nextPc, tgt(32'h1000, 16'h0040));
    slotNop("R5", 1'b0);
    drive(1'b1, 2'b01, 1'b0, 1'b0, 32'd5, 5'd3, 32'h1000, 16'h0040, 1'b0, 5'd0);
    cmp("R1", "eqz nonzero", {31'd0, taken}, 32'd0);
    cmp("R3", "eqz fallthru", nextPc, 32'h1008);
  endtask

  task automatic t_nez;
    drive(1'b1, 2'b10, 1'b0, 1'b0, 32'h8000_0000, 5'd7, 32'h2000, 16'hFFF0, 1'b0, 5'd0);
    cmp("R1", "nez msb taken", {31'd0, taken}, 32'd1);
    cmp("R2", "nez negative target", nextPc, 32'h0000_1FF4);
    drive(1'b1, 2'b10, 1'b0, 1'b1, 32'd0, 5'd7, 32'h2000, 16'hFFF0, 1'b0, 5'd0);
    cmp("R1", "nez zero", {31'd0, taken}, 32'd0);
    cmp("R3", "nez fallthru", nextPc, 32'h2008);
    slotNop("R5", 1'b0);
  endtask

  task automatic t_reserved;
    drive(1'b1, 2'b11, 1'b1, 1'b1, 32'd0, 5'd2, 32'h3000, 16'h8, 1'b1, 5'd2);
    cmp("R4", "reserved taken", {31'd0, taken}, 32'd0);
    cmp("R4", "reserved stall", {31'd0, stall}, 32'd0);
    slotNop("R4", 1'b0);
  endtask

  task automatic t_cancel;
    drive(1'b1, 2'b01, 1'b1, 1'b1, 32'd0, 5'd1, 32'h5000, 16'h20, 1'b0, 5'd0);
    slotNop("R6", 1'b0);
    drive(1'b1, 2'b01, 1'b1, 1'b0, 32'd0, 5'd1, 32'h5000, 16'h20, 1'b0, 5'd0);
    cmp("R6", "taken cancel", {31'd0, taken}, 32'd1);
    slotNop("R6", 1'b1);
    slotNop("R6", 1'b0);
    drive(1'b1, 2'b01, 1'b1, 1'b1, 32'd9, 5'd1, 32'h5000, 16'h20, 1'b0, 5'd0);
    slotNop("R6", 1'b1);
    drive(1'b1, 2'b01, 1'b1, 1'b0, 32'd9, 5'd1, 32'h5000, 16'h20, 1'b0, 5'd0);
    slotNop("R6", 1'b0);
  endtask

  task automatic t_hazard;
    drive(1'b1, 2'b01, 1'b1, 1'b0, 32'd0, 5'd4, 32'h6000, 16'h10, 1'b1, 5'd4);
    cmp("R7", "stall", {31'd0, stall}, 32'd1);
    cmp("R7", "taken during stall", {31'd0, taken}, 32'd0);
    cmp("R7", "nextPc during stall", nextPc, 32'h6008);
    drive(1'b1, 2'b01, 1'b1, 1'b0, 32'd0, 5'd4, 32'h6000, 16'h10, 1'b0, 5'd0);
    cmp("R7", "squash after stall", {31'd0, squashSlot}, 32'd0);
    cmp("R7", "resolved taken", {31'd0, taken}, 32'd1);
    cmp("R7", "resolved target", nextPc, tgt(32'h6000, 16'h10));
    slotNop("R7", 1'b1);
  endtask

  task automatic t_branchInSlot;
    drive(1'b1, 2'b10, 1'b1, 1'b1, 32'd0, 5'd6, 32'h7000, 16'h10, 1'b0, 5'd0);
    drive(1'b1, 2'b01, 1'b1, 1'b0, 32'd0, 5'd6, 32'h7004, 16'h10, 1'b1, 5'd6);
    cmp("R8", "slot flagged", {31'd0, squashSlot}, 32'd1);
    cmp("R8", "slot branch taken", {31'd0, taken}, 32'd0);
    cmp("R8", "slot branch stall", {31'd0, stall}, 32'd0);
    slotNop("R8", 1'b0);
  endtask

  task automatic t_nonBranchMatch;
    drive(1'b1, 2'b00, 1'b0, 1'b0, 32'd0, 5'd9, 32'h8000, 16'h10, 1'b1, 5'd9);
    cmp("R10", "non-branch stall", {31'd0, stall}, 32'd0);
    cmp("R10", "non-branch nextPc", nextPc, 32'h8008);
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idValid = 1'b0; idBrType = 2'b00; idCancel = 1'b0; idPredict = 1'b0;
    idRegVal = '0; idRegIdx = '0; idPc = '0; idOffset = '0; fetchPcPlus4 = '0;
    exWrEn = 1'b0; exWrIdx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    t_reset();
    t_eqz();
    t_nez();
    t_reserved();
    t_cancel();
    t_hazard();
    t_branchInSlot();
    t_nonBranchMatch();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule